// File: doc/BRIEF.md
# Tiled Image Gradient Unit

This block computes the horizontal and vertical first-difference gradients of a grayscale frame. A host fills the on-block frame store through a word-wide load port, pulses `start`, waits for `done`, and then reads the two result stores through a shared read address. Each word holds four neighbouring pixels of one row. Pixels and results are 16-bit two's-complement values.

The frame is walked in 4x4 tiles, in raster order. For each tile the unit reads six aligned words from the frame store: the row above the tile, the four tile rows, and the row below. It first produces the four vertical-gradient rows. It then steps through the tile column by column, so that the four lanes carry the four tile rows, and produces the horizontal gradients. A single bank of four subtractors serves both passes. The edge of the frame is handled inside each lane by a predicate: a lane that sits on an edge uses itself in place of the missing neighbour, which turns the central difference into a one-sided difference. The column of pixels to the left of a tile is kept from the previous tile, and the column to its right comes from the next tile's fetch. Neither is read a second time.

Top module: `grad_tile_engine`

## Requirements
- R1: While reset is asserted and after its release, `done` is low and no run is in progress.
- R2: Pixel (r,c) lives at word address r*(COLS/4)+c/4, in lane c%4, on bits [16*(c%4)+15 : 16*(c%4)]. The load port and both result stores use this layout. Result data appears on `rd_dx`/`rd_dy` one clock after `rd_addr` is presented.
- R3: For 0 < c < COLS-1, the horizontal result is p(r,c+1) - p(r,c-1).
- R4: In column 0 the horizontal result is p(r,1) - p(r,0). In column COLS-1 it is p(r,COLS-1) - p(r,COLS-2).
- R5: For 0 < r < ROWS-1, the vertical result is p(r+1,c) - p(r-1,c).
- R6: In row 0 the vertical result is p(1,c) - p(0,c). In row ROWS-1 it is p(ROWS-1,c) - p(ROWS-2,c).
- R7: Every difference wraps modulo 2^16 and is never saturated.
- R8: `done` rises on the second clock edge after the last result word is written. It then stays high until the next `start`. A `start` while idle clears `done` at the next edge.
- R9: A `start` that arrives during a run is ignored. The run neither restarts nor changes its completion time or its results.
- R10: Each run writes every horizontal and vertical result word exactly once. It reads the frame store only at in-range word addresses. At most one store access by the engine occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Frame store write enable |
| ld_addr | input | ADDR_W | Frame store word address |
| ld_data | input | 4*PIX_W | Four pixels for the addressed word |
| start | input | 1 | Begin a run when idle |
| done | output | 1 | Run finished; held until next start |
| rd_addr | input | ADDR_W | Result word address |
| rd_dx | output | 4*PIX_W | Horizontal gradient word, one clock after the address |
| rd_dy | output | 4*PIX_W | Vertical gradient word, one clock after the address |

## Verification
The assertions assume that the host leaves the frame store alone while a run is in progress. They also assume that `start` is a plain pulse. The write-count check relies on that, because it counts from the accepted `start` to the rise of `done`. The stimulus loads each frame only while the unit is idle, and raises `start` mid-run only on purpose, to exercise the ignore rule. It reads the result stores only after `done` and only at addresses inside the frame. The pixel patterns come from a seeded hash, an alternating extreme-value checkerboard that forces wraparound, and a linear ramp whose edge and interior gradients are known constants.

// File: rtl/grad_pkg.sv
package grad_pkg;

  // Tile edge in pixels; lanes per word equals tile width
  localparam int TILE      = 4;
  // Rows fetched per tile: one halo above, tile rows, one halo below
  localparam int FROWS     = TILE + 2;
  // Fetch phase length: one read per fetched row plus read latency
  localparam int FETCH_CYC = FROWS + 1;
  // Compute phase: vertical rows, horizontal columns, horizontal write-back
  localparam int CALC_CYC  = 3 * TILE;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_CALC,
    S_ADV
  } seq_state_e;

  // Clamp a signed index into [0, n-1]
  function automatic int clamp_idx(input int v, input int n);
    if (v < 0) return 0;
    if (v > n - 1) return n - 1;
    return v;
  endfunction

endpackage

// File: rtl/grad_fbuf.sv
module grad_fbuf #(
  parameter int W     = 64,
  parameter int DEPTH = 2500,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/grad_sub4.sv
module grad_sub4 #(
  parameter int LANES = 4,
  parameter int W     = 16
) (
  input  logic [LANES-1:0][W-1:0] hi_i,
  input  logic [LANES-1:0][W-1:0] mid_i,
  input  logic [LANES-1:0][W-1:0] lo_i,
  input  logic [LANES-1:0]        first_i,
  input  logic [LANES-1:0]        last_i,
  output logic [LANES-1:0][W-1:0] diff_o
);

  // Edge predicate swaps a missing neighbour for the pixel itself
  function automatic logic [W-1:0] edge_diff(
    input logic [W-1:0] hi,
    input logic [W-1:0] mid,
    input logic [W-1:0] lo,
    input logic         at_first,
    input logic         at_last
  );
    logic [W-1:0] up;
    logic [W-1:0] dn;
    up = at_last  ? mid : hi;
    dn = at_first ? mid : lo;
    return up - dn;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign diff_o[g] = edge_diff(hi_i[g], mid_i[g], lo_i[g], first_i[g], last_i[g]);
  end

endmodule

// File: rtl/grad_seq.sv
module grad_seq
  import grad_pkg::*;
#(
  parameter int TCOLS = 25,
  parameter int TROWS = 25,
  parameter int SW    = $clog2(TCOLS + 1),
  parameter int RW    = (TROWS > 1) ? $clog2(TROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output seq_state_e    st,
  output logic [3:0]    ph,
  output logic [SW-1:0] step,
  output logic [RW-1:0] trow,
  output logic          done
);

  localparam logic [SW-1:0] STEP_END  = SW'(TCOLS);
  localparam logic [SW-1:0] STEP_LAST = SW'(TCOLS - 1);
  localparam logic [RW-1:0] TROW_LAST = RW'(TROWS - 1);
  localparam logic [3:0]    FETCH_END = 4'(FETCH_CYC - 1);
  localparam logic [3:0]    CALC_END  = 4'(CALC_CYC - 1);

  // step counts fetches along a tile row; the tile computed is step-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= '0;
      step <= '0;
      trow <= '0;
      done <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start) begin
            done <= 1'b0;
            step <= '0;
            trow <= '0;
            ph   <= '0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (ph == FETCH_END) begin
            ph <= '0;
            st <= (step == '0) ? S_ADV : S_CALC;
          end else begin
            ph <= ph + 4'd1;
          end
        end
        S_CALC: begin
          if (ph == CALC_END) begin
            ph <= '0;
            st <= S_ADV;
          end else begin
            ph <= ph + 4'd1;
          end
        end
        S_ADV: begin
          if (step == STEP_END) begin
            step <= '0;
            if (trow == TROW_LAST) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              trow <= trow + RW'(1);
              st   <= S_FETCH;
            end
          end else begin
            step <= step + SW'(1);
            st   <= (step == STEP_LAST) ? S_CALC : S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/grad_tile_engine.sv
module grad_tile_engine
  import grad_pkg::*;
#(
  parameter int ROWS   = 100,
  parameter int COLS   = 100,
  parameter int PIX_W  = 16,
  parameter int ADDR_W = $clog2(ROWS * COLS / TILE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_we,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [TILE*PIX_W-1:0]   ld_data,
  input  logic                    start,
  output logic                    done,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [TILE*PIX_W-1:0]   rd_dx,
  output logic [TILE*PIX_W-1:0]   rd_dy
);

  localparam int TCOLS = COLS / TILE;
  localparam int TROWS = ROWS / TILE;
  localparam int WORDS = ROWS * TCOLS;
  localparam int SW    = $clog2(TCOLS + 1);
  localparam int RW    = (TROWS > 1) ? $clog2(TROWS) : 1;
  localparam int LW    = $clog2(TILE);
  localparam int BW    = $clog2(FROWS);

  localparam logic [SW-1:0] TC_LAST   = SW'(TCOLS - 1);
  localparam logic [RW-1:0] TROW_LAST = RW'(TROWS - 1);

  typedef logic [TILE-1:0][PIX_W-1:0] word_t;

  seq_state_e    st;
  logic [3:0]    ph;
  logic [SW-1:0] step;
  logic [RW-1:0] trow;
  logic [SW-1:0] tc;
  int            sel;

  // Named events for the checker
  logic fetch_re, fetch_cap, calc_dy, calc_dx, dy_we, dx_we, adv, busy;

  logic [ADDR_W-1:0] fb_raddr;
  logic [ADDR_W-1:0] out_addr;
  word_t             fb_rdata;

  // Fetched block (halo row, tile rows, halo row), block under compute,
  // retained left-neighbour column, and horizontal results awaiting write-back
  logic [FROWS-1:0][TILE-1:0][PIX_W-1:0] nb, cb;
  word_t                                 lcol;
  logic [TILE-1:0][TILE-1:0][PIX_W-1:0]  dxt;

  word_t           hi_v, mid_v, lo_v, diff_v;
  logic [TILE-1:0] fm, lm;

  grad_seq #(.TCOLS(TCOLS), .TROWS(TROWS), .SW(SW), .RW(RW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .st    (st),
    .ph    (ph),
    .step  (step),
    .trow  (trow),
    .done  (done)
  );

  assign tc  = step - SW'(1);
  assign sel = int'(ph) % TILE;

  assign busy      = (st != S_IDLE);
  assign adv       = (st == S_ADV);
  assign fetch_re  = (st == S_FETCH) && (ph < 4'(FROWS));
  assign fetch_cap = (st == S_FETCH) && (ph != 4'd0);
  assign calc_dy   = (st == S_CALC) && (ph < 4'(TILE));
  assign calc_dx   = (st == S_CALC) && (ph >= 4'(TILE)) && (ph < 4'(2 * TILE));
  assign dx_we     = (st == S_CALC) && (ph >= 4'(2 * TILE));
  assign dy_we     = calc_dy;

  // Aligned word addresses: frame fetch row is clamped into the frame
  always_comb begin
    int frow;
    int orow;
    frow     = clamp_idx(int'(trow) * TILE - 1 + int'(ph), ROWS);
    fb_raddr = ADDR_W'(frow * TCOLS + int'(step));
    orow     = int'(trow) * TILE + sel;
    out_addr = ADDR_W'(orow * TCOLS + int'(tc));
  end

  // Operand steering: rows as lanes for vertical, columns walked for horizontal
  always_comb begin
    hi_v  = '0;
    mid_v = '0;
    lo_v  = '0;
    fm    = '0;
    lm    = '0;
    if (calc_dy) begin
      for (int l = 0; l < TILE; l++) begin
        hi_v[LW'(l)]  = cb[BW'(sel + 2)][LW'(l)];
        mid_v[LW'(l)] = cb[BW'(sel + 1)][LW'(l)];
        lo_v[LW'(l)]  = cb[BW'(sel)][LW'(l)];
        fm[LW'(l)]    = (trow == '0) && (sel == 0);
        lm[LW'(l)]    = (trow == TROW_LAST) && (sel == TILE - 1);
      end
    end else if (calc_dx) begin
      for (int k = 0; k < TILE; k++) begin
        mid_v[LW'(k)] = cb[BW'(k + 1)][LW'(sel)];
        if (sel == TILE - 1) hi_v[LW'(k)] = nb[BW'(k + 1)][0];
        else                 hi_v[LW'(k)] = cb[BW'(k + 1)][LW'(sel + 1)];
        if (sel == 0) lo_v[LW'(k)] = lcol[LW'(k)];
        else          lo_v[LW'(k)] = cb[BW'(k + 1)][LW'(sel - 1)];
        fm[LW'(k)] = (tc == '0) && (sel == 0);
        lm[LW'(k)] = (tc == TC_LAST) && (sel == TILE - 1);
      end
    end
  end

  grad_sub4 #(.LANES(TILE), .W(PIX_W)) u_sub (
    .hi_i    (hi_v),
    .mid_i   (mid_v),
    .lo_i    (lo_v),
    .first_i (fm),
    .last_i  (lm),
    .diff_o  (diff_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb   <= '0;
      cb   <= '0;
      lcol <= '0;
      dxt  <= '0;
    end else begin
      if (fetch_cap) nb[BW'(int'(ph) - 1)] <= fb_rdata;
      if (calc_dx) begin
        for (int k = 0; k < TILE; k++) dxt[LW'(k)][LW'(sel)] <= diff_v[LW'(k)];
      end
      if (adv) begin
        for (int k = 0; k < TILE; k++) lcol[LW'(k)] <= cb[BW'(k + 1)][TILE-1];
        cb <= nb;
      end
    end
  end

  grad_fbuf #(.W(TILE * PIX_W), .DEPTH(WORDS), .AW(ADDR_W)) u_frame (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (fb_raddr),
    .rdata (fb_rdata)
  );

  grad_fbuf #(.W(TILE * PIX_W), .DEPTH(WORDS), .AW(ADDR_W)) u_dy (
    .clk   (clk),
    .we    (dy_we),
    .waddr (out_addr),
    .wdata (diff_v),
    .raddr (rd_addr),
    .rdata (rd_dy)
  );

  grad_fbuf #(.W(TILE * PIX_W), .DEPTH(WORDS), .AW(ADDR_W)) u_dx (
    .clk   (clk),
    .we    (dx_we),
    .waddr (out_addr),
    .wdata (dxt[LW'(sel)]),
    .raddr (rd_addr),
    .rdata (rd_dx)
  );

endmodule

// File: rtl/grad_tile_engine_chk.sv
module grad_tile_engine_chk #(
  parameter int WORDS  = 2500,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              busy,
  input logic              fetch_re,
  input logic [ADDR_W-1:0] fb_raddr,
  input logic              dy_we,
  input logic              dx_we,
  input logic [ADDR_W-1:0] out_addr
);

  int unsigned dy_cnt;
  int unsigned dx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dy_cnt <= 0;
      dx_cnt <= 0;
    end else if (start && !busy) begin
      dy_cnt <= 0;
      dx_cnt <= 0;
    end else begin
      if (dy_we) dy_cnt <= dy_cnt + 1;
      if (dx_we) dx_cnt <= dx_cnt + 1;
    end
  end

  assert_frame_rd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_re |-> (fb_raddr < ADDR_W'(WORDS)));

  assert_result_wr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dy_we || dx_we) |-> (out_addr < ADDR_W'(WORDS)));

  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_re, dy_we, dx_we}));

  assert_word_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (dy_cnt == WORDS) && (dx_cnt == WORDS));

  assert_done_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(dx_we, 2) && !$past(dx_we));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!done && busy));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fetch_re || dy_we || dx_we));

  assert_no_done_midrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

endmodule

bind grad_tile_engine grad_tile_engine_chk #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .busy     (busy),
  .fetch_re (fetch_re),
  .fb_raddr (fb_raddr),
  .dy_we    (dy_we),
  .dx_we    (dx_we),
  .out_addr (out_addr)
);

// File: tb/test_grad_tile_engine.sv
module test_grad_tile_engine;

  localparam int ROWS  = 100;
  localparam int COLS  = 100;
  localparam int PW    = 16;
  localparam int L     = 4;
  localparam int TC    = COLS / L;
  localparam int WORDS = ROWS * TC;
  localparam int AW    = $clog2(WORDS);
  localparam int LIMIT = 40000;

  logic            clk     = 1'b0;
  logic            rst_n   = 1'b0;
  logic            ld_we   = 1'b0;
  logic [AW-1:0]   ld_addr = '0;
  logic [L*PW-1:0] ld_data = '0;
  logic            start   = 1'b0;
  logic            done;
  logic [AW-1:0]   rd_addr = '0;
  logic [L*PW-1:0] rd_dx;
  logic [L*PW-1:0] rd_dy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit aborted = 1'b0;

  always #2.5ns clk = ~clk;

  grad_tile_engine #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PW)) i_grad_tile_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_we   (ld_we),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .start   (start),
    .done    (done),
    .rd_addr (rd_addr),
    .rd_dx   (rd_dx),
    .rd_dy   (rd_dy)
  );

  // Pixel generator: the frame is never stored in the bench
  function automatic logic [15:0] pix(input int pat, input int unsigned sd, input int r, input int c);
    int unsigned x;
    case (pat)
      0: begin
        x = sd + 32'(r) * 32'd1103515245 + 32'(c) * 32'd12345;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x[15:0];
      end
      1: return (((r + c) % 2) == 1) ? 16'h7FFF : 16'h8000;
      default: return 16'(r * COLS + c);
    endcase
  endfunction

  function automatic logic [15:0] exp_dx(input int pat, input int unsigned sd, input int r, input int c);
    int right;
    int left;
    right = (c == COLS - 1) ? c : c + 1;
    left  = (c == 0) ? c : c - 1;
    return pix(pat, sd, r, right) - pix(pat, sd, r, left);
  endfunction

  function automatic logic [15:0] exp_dy(input int pat, input int unsigned sd, input int r, input int c);
    int below;
    int above;
    below = (r == ROWS - 1) ? r : r + 1;
    above = (r == 0) ? r : r - 1;
    return pix(pat, sd, below, c) - pix(pat, sd, above, c);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2: word w carries row w/TC, columns (w%TC)*4 + lane
  task automatic load_frame(input int pat, input int unsigned sd);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      ld_we   = 1'b1;
      ld_addr = AW'(w);
      for (int l = 0; l < L; l++) ld_data[l*PW +: PW] = pix(pat, sd, w / TC, (w % TC) * L + l);
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run_frame(input bit poke, output int cyc);
    bit was_done;
    was_done = done;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (was_done) check(done == 1'b0, "R8", "done cleared by start", int'(done), 0);
    while (!done && cyc < LIMIT) begin
      // R9: extra start pulses while running
      start = poke && (cyc == 100 || cyc == 7000);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      check(1'b0, "R8", "run watchdog expired", cyc, LIMIT);
      aborted = 1'b1;
    end
  endtask

  task automatic check_frame(input int pat, input int unsigned sd);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      rd_addr = AW'(w);
      @(negedge clk);
      for (int l = 0; l < L; l++) begin
        int r;
        int c;
        string tx;
        string ty;
        r  = w / TC;
        c  = (w % TC) * L + l;
        tx = (c == 0 || c == COLS - 1) ? "R4" : "R3";
        ty = (r == 0 || r == ROWS - 1) ? "R6" : "R5";
        if (pat == 1) begin
          tx = {tx, " R7"};
          ty = {ty, " R7"};
        end
        check(rd_dx[l*PW +: PW] == exp_dx(pat, sd, r, c), {tx, " R2"},
              $sformatf("dx r=%0d c=%0d", r, c), int'(rd_dx[l*PW +: PW]), int'(exp_dx(pat, sd, r, c)));
        check(rd_dy[l*PW +: PW] == exp_dy(pat, sd, r, c), {ty, " R2"},
              $sformatf("dy r=%0d c=%0d", r, c), int'(rd_dy[l*PW +: PW]), int'(exp_dy(pat, sd, r, c)));
      end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    int unsigned sd_a;
    int unsigned sd_b;
    int cyc_a;
    int cyc_b;
    int cyc_c;
    sd_a = $urandom(32'd7341);
    sd_b = $urandom;

    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1", "done during reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // Random frame: interior and edge masks (R3 R4 R5 R6)
    load_frame(0, sd_a);
    run_frame(1'b0, cyc_a);
    if (!aborted) check_frame(0, sd_a);

    // R8: done held while idle
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R8", "done held while idle", int'(done), 1);

    // Extreme checkerboard forces wraparound (R7); start pokes mid-run (R9)
    if (!aborted) begin
      load_frame(1, 0);
      run_frame(1'b1, cyc_b);
      check(cyc_b == cyc_a, "R9", "run length with mid-run start", cyc_b, cyc_a);
      if (!aborted) check_frame(1, 0);
    end

    // Ramp: known constant gradients, R10 every word readable
    if (!aborted) begin
      load_frame(2, 0);
      run_frame(1'b0, cyc_c);
      check(cyc_c == cyc_a, "R9", "run length stable", cyc_c, cyc_a);
      if (!aborted) check_frame(2, 0);
    end

    // Second random frame
    if (!aborted) begin
      load_frame(0, sd_b);
      run_frame(1'b0, cyc_c);
      if (!aborted) check_frame(0, sd_b);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule